// File: doc/BRIEF.md
# Single-Wire Debug Command Sequencer

This block is the host end of a one-wire debug link. The link is an open-drain line with a pull-up. Software or a controlling state machine gives the block one command at a time. A command is an 8-bit opcode, a command class, a 16-bit address and 16-bit write data. The class decides which of these fields go onto the wire and in what order.

The block drives the line low through an output enable and never drives it high. Each bit is a cell measured in target-clock periods. Between fields, and after the last field, the block inserts the wait that the command class requires. That wait is counted in bus-clock periods. For read classes, the block captures 16 data bits returned by the target and presents them as the read result.

Two programmable dividers derive the target-period tick and the bus-period tick from the system clock. The ratio between the two rates can therefore be set at run time. Busy stays high from the accepted request until the frame and its wait have both finished. A one-cycle done pulse marks the end of the command.

Top module: `dbgwire_seq`

## Requirements
- R1: After reset and whenever no command is in progress, `busy`, `done` and `line_oe` are 0 and `rdata` is 0 until the first read completes; the line is driven only while `busy` is 1.
- R2: Each transmitted cell starts with `line_oe` rising. For a 1 bit, `line_oe` stays high for exactly 4 target periods; for a 0 bit it stays high for exactly 13. One target period is `tgt_div` system clocks. Consecutive cells start 16 target periods plus 0 to 4 system clocks apart.
- R3: The 8-bit opcode is always sent first, most significant bit first; address and data fields are 16 bits and also go out most significant bit first.
- R4: Class encodings and frame shapes: 0 = opcode only; 1 = memory read (opcode, address, wait, read data); 2 = memory write (opcode, address, write data, wait); 3 = short read (opcode, wait, read data); 4 = short write (opcode, write data, wait); 5 = resume (opcode, wait); codes 6 and 7 behave as 0.
- R5: In a read cell the host drives low for exactly 4 target periods, then releases the line. It samples the line level 10 target periods into the cell. The 16 sampled bits, first bit most significant, become `rdata`.
- R6: Classes 1 and 2 wait 150 bus periods (`bus_div` system clocks each), with the line released. For class 1 the wait sits between the address and the read data; for class 2 it follows the write data and comes before `done`. In both cases the measured gap is 150 bus periods plus 0 to 4 system clocks.
- R7: Class 3 waits 48 bus periods before its read data. Class 4 waits 36 bus periods after its write data and before `done`. Both gaps carry the same slack as in R6.
- R8: Class 5 waits 76 bus periods after its opcode before `done`, with the same slack as in R6.
- R9: A request is taken only while `busy` is 0. Requests and changes on the command inputs while busy alter neither the frame in progress nor what follows it.
- R10: `done` is a single-cycle pulse in the first cycle `busy` is 0. `rdata` changes only at the end of a read class; write, resume and opcode-only commands leave it unchanged.
- R11: A synchronous reset asserted in the middle of a frame releases the line, clears `busy`, and leaves the block ready to run a new command normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_div | input | 8 | System clocks per bus period (0 acts as 1) |
| tgt_div | input | 8 | System clocks per target period (0 acts as 1) |
| req | input | 1 | Command request, sampled while idle |
| cmd_op | input | 8 | Command opcode |
| cmd_cls | input | 3 | Command class code |
| cmd_addr | input | 16 | Address field |
| cmd_wdata | input | 16 | Write data field |
| busy | output | 1 | Command in progress, including its wait |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Last captured read data |
| line_oe | output | 1 | Pull the debug line low when 1 |
| line_in | input | 1 | Level seen on the debug line |

## Verification
The case to provoke is a new request that coincides with the end of a command's mandatory wait. The end of the wait and the acceptance of a request must never fall on the same cycle. In one scenario the bench raises `req` with a different class, opcode and data early in a memory write and holds it through the address, the data and the 150-period wait. It lowers `req` in the cycle `done` appears. The bench then judges the result at the line: the frame must carry exactly the originally latched cells, the wait must still measure its full length, and no further cell may appear once the block returns to idle.

// File: rtl/dbgwire_pkg.sv
package dbgwire_pkg;

  typedef enum logic [2:0] {
    CLS_BARE   = 3'd0,
    CLS_MEM_RD = 3'd1,
    CLS_MEM_WR = 3'd2,
    CLS_FW_RD  = 3'd3,
    CLS_FW_WR  = 3'd4,
    CLS_RESUME = 3'd5
  } cls_e;

  typedef enum logic [2:0] {
    PH_IDLE, PH_OPC, PH_ADR, PH_WDT, PH_WAIT, PH_RDT
  } phase_e;

  function automatic logic cls_has_addr(input logic [2:0] c);
    return (c == CLS_MEM_RD) || (c == CLS_MEM_WR);
  endfunction

  function automatic logic cls_has_wdata(input logic [2:0] c);
    return (c == CLS_MEM_WR) || (c == CLS_FW_WR);
  endfunction

  function automatic logic cls_is_read(input logic [2:0] c);
    return (c == CLS_MEM_RD) || (c == CLS_FW_RD);
  endfunction

  function automatic logic cls_has_wait(input logic [2:0] c);
    return (c >= CLS_MEM_RD) && (c <= CLS_RESUME);
  endfunction

  // Bus periods to wait for a class; 0 for classes without a wait.
  function automatic int unsigned wait_ticks(input logic [2:0] c, input int unsigned mem,
                                             input int unsigned srd, input int unsigned swr,
                                             input int unsigned res);
    case (c)
      CLS_MEM_RD, CLS_MEM_WR: return mem;
      CLS_FW_RD:              return srd;
      CLS_FW_WR:              return swr;
      CLS_RESUME:             return res;
      default:                return 0;
    endcase
  endfunction

  // Target periods the host holds the line low in one cell.
  function automatic int unsigned cell_low(input logic rx, input logic b,
                                           input int unsigned one_tc, input int unsigned zero_tc);
    if (rx || b) return one_tc;
    return zero_tc;
  endfunction

  // Phase that follows the current one once it finishes.
  function automatic phase_e next_phase(input phase_e p, input logic [2:0] c);
    phase_e n;
    n = PH_IDLE;
    case (p)
      PH_OPC: begin
        if (cls_has_addr(c))       n = PH_ADR;
        else if (cls_has_wdata(c)) n = PH_WDT;
        else if (cls_has_wait(c))  n = PH_WAIT;
      end
      PH_ADR:  n = cls_has_wdata(c) ? PH_WDT : PH_WAIT;
      PH_WDT:  n = PH_WAIT;
      PH_WAIT: n = cls_is_read(c) ? PH_RDT : PH_IDLE;
      default: n = PH_IDLE;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/dbgwire_tick.sv
module dbgwire_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim;

  assign lim  = (div == '0) ? DIV_W'(1) : div;
  assign tick = (cnt >= lim - DIV_W'(1));

  always_ff @(posedge clk) begin
    if (rst || clr)  cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + DIV_W'(1);
  end
endmodule

// File: rtl/dbgwire_cell.sv
module dbgwire_cell
  import dbgwire_pkg::*;
#(
  parameter int CELL_TC   = 16,
  parameter int ONE_TC    = 4,
  parameter int ZERO_TC   = 13,
  parameter int SAMPLE_TC = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic go,
  input  logic tx_bit,
  input  logic rx_mode,
  input  logic ttick,
  input  logic line_lvl,
  output logic drive_low,
  output logic cell_done,
  output logic rx_bit
);
  localparam int TC_W = $clog2(CELL_TC + 1);

  logic [TC_W-1:0] tc;
  logic [TC_W-1:0] low_tc;
  logic            act;
  logic            mode_rx;
  logic            bit_q;

  assign low_tc    = TC_W'(cell_low(mode_rx, bit_q, ONE_TC, ZERO_TC));
  assign drive_low = act && (tc < low_tc);

  always_ff @(posedge clk) begin
    if (rst) begin
      act       <= 1'b0;
      tc        <= '0;
      mode_rx   <= 1'b0;
      bit_q     <= 1'b0;
      rx_bit    <= 1'b0;
      cell_done <= 1'b0;
    end else begin
      cell_done <= 1'b0;
      if (go) begin
        act     <= 1'b1;
        tc      <= '0;
        mode_rx <= rx_mode;
        bit_q   <= tx_bit;
      end else if (act && ttick) begin
        if (mode_rx && tc == TC_W'(SAMPLE_TC - 1)) rx_bit <= line_lvl;
        if (tc == TC_W'(CELL_TC - 1)) begin
          act       <= 1'b0;
          tc        <= '0;
          cell_done <= 1'b1;
        end else begin
          tc <= tc + TC_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/dbgwire_wait.sv
module dbgwire_wait #(
  parameter int DLY_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [DLY_W-1:0] len,
  input  logic             btick,
  output logic             expired,
  output logic             running
);
  logic [DLY_W-1:0] cnt;

  assign running = (cnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      expired <= 1'b0;
    end else begin
      expired <= 1'b0;
      if (load) begin
        cnt <= len;
      end else if (running && btick) begin
        cnt <= cnt - DLY_W'(1);
        if (cnt == DLY_W'(1)) expired <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dbgwire_seq.sv
module dbgwire_seq
  import dbgwire_pkg::*;
#(
  parameter int DIV_W      = 8,
  parameter int OP_W       = 8,
  parameter int DATA_W     = 16,
  parameter int CELL_TC    = 16,
  parameter int ONE_TC     = 4,
  parameter int ZERO_TC    = 13,
  parameter int SAMPLE_TC  = 10,
  parameter int DLY_MEM    = 150,
  parameter int DLY_RESUME = 76,
  parameter int DLY_SRD    = 48,
  parameter int DLY_SWR    = 36
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DIV_W-1:0]  bus_div,
  input  logic [DIV_W-1:0]  tgt_div,
  input  logic              req,
  input  logic [OP_W-1:0]   cmd_op,
  input  logic [2:0]        cmd_cls,
  input  logic [DATA_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              line_oe,
  input  logic              line_in
);
  localparam int DLY_W = $clog2(DLY_MEM + DLY_RESUME + DLY_SRD + DLY_SWR + 1);
  localparam int BIT_W = $clog2(DATA_W) + 1;

  phase_e            ph;
  phase_e            nxt;
  logic [2:0]        cls_q;
  logic [DATA_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] sh;
  logic [DATA_W-1:0] rxsh;
  logic [BIT_W-1:0]  left;
  logic              fire;
  logic              wait_go;
  logic [1:0]        sync;

  // Named internal events
  logic ttick, btick;
  logic cell_done, rx_bit, drive_low;
  logic dly_exp, dly_run;
  logic in_field, last_cell, advance;
  logic [DLY_W-1:0] wait_len;

  assign in_field  = (ph == PH_OPC) || (ph == PH_ADR) || (ph == PH_WDT) || (ph == PH_RDT);
  assign last_cell = in_field && cell_done && (left == BIT_W'(1));
  assign advance   = last_cell || ((ph == PH_WAIT) && dly_exp);
  assign nxt       = next_phase(ph, cls_q);
  assign wait_len  = DLY_W'(wait_ticks(cls_q, DLY_MEM, DLY_SRD, DLY_SWR, DLY_RESUME));

  assign busy    = (ph != PH_IDLE);
  assign line_oe = drive_low;

  always_ff @(posedge clk) begin
    if (rst) sync <= 2'b11;
    else     sync <= {sync[0], line_in};
  end

  dbgwire_tick #(.DIV_W(DIV_W)) u_tdiv (
    .clk(clk), .rst(rst), .clr(fire), .div(tgt_div), .tick(ttick)
  );

  dbgwire_tick #(.DIV_W(DIV_W)) u_bdiv (
    .clk(clk), .rst(rst), .clr(wait_go), .div(bus_div), .tick(btick)
  );

  dbgwire_cell #(
    .CELL_TC(CELL_TC), .ONE_TC(ONE_TC), .ZERO_TC(ZERO_TC), .SAMPLE_TC(SAMPLE_TC)
  ) u_cell (
    .clk(clk), .rst(rst), .go(fire), .tx_bit(sh[DATA_W-1]),
    .rx_mode(ph == PH_RDT), .ttick(ttick), .line_lvl(sync[1]),
    .drive_low(drive_low), .cell_done(cell_done), .rx_bit(rx_bit)
  );

  dbgwire_wait #(.DLY_W(DLY_W)) u_wait (
    .clk(clk), .rst(rst), .load(wait_go), .len(wait_len), .btick(btick),
    .expired(dly_exp), .running(dly_run)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ph      <= PH_IDLE;
      cls_q   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      sh      <= '0;
      rxsh    <= '0;
      left    <= '0;
      fire    <= 1'b0;
      wait_go <= 1'b0;
      done    <= 1'b0;
      rdata   <= '0;
    end else begin
      fire    <= 1'b0;
      wait_go <= 1'b0;
      done    <= 1'b0;
      if (ph == PH_IDLE) begin
        if (req) begin
          cls_q   <= cmd_cls;
          addr_q  <= cmd_addr;
          wdata_q <= cmd_wdata;
          sh      <= {cmd_op, {(DATA_W-OP_W){1'b0}}};
          rxsh    <= '0;
          left    <= BIT_W'(OP_W);
          ph      <= PH_OPC;
          fire    <= 1'b1;
        end
      end else if (advance) begin
        ph <= nxt;
        case (nxt)
          PH_ADR: begin sh <= addr_q;  left <= BIT_W'(DATA_W); fire <= 1'b1; end
          PH_WDT: begin sh <= wdata_q; left <= BIT_W'(DATA_W); fire <= 1'b1; end
          PH_RDT: begin left <= BIT_W'(DATA_W); fire <= 1'b1; end
          PH_WAIT: wait_go <= 1'b1;
          default: begin
            done <= 1'b1;
            if (cls_is_read(cls_q)) rdata <= {rxsh[DATA_W-2:0], rx_bit};
          end
        endcase
      end else if (in_field && cell_done) begin
        sh   <= sh << 1;
        left <= left - BIT_W'(1);
        fire <= 1'b1;
        if (ph == PH_RDT) rxsh <= {rxsh[DATA_W-2:0], rx_bit};
      end
    end
  end
endmodule

// File: rtl/dbgwire_seq_chk.sv
module dbgwire_seq_chk #(
  parameter int DIV_W   = 8,
  parameter int ZERO_TC = 13,
  parameter int DATA_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              done,
  input logic              line_oe,
  input logic              dly_run,
  input logic [DIV_W-1:0]  tgt_div,
  input logic [DATA_W-1:0] rdata
);
  int unsigned low_run;
  int unsigned low_cap;

  assign low_cap = ZERO_TC * ((tgt_div == '0) ? 1 : int'(tgt_div));

  always_ff @(posedge clk) begin
    if (rst)          low_run <= 0;
    else if (line_oe) low_run <= low_run + 1;
    else              low_run <= 0;
  end

  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (!busy && !line_oe && !done)); // R11
  AST_DRIVE_IN_FRAME: assert property (@(posedge clk) disable iff (rst) line_oe |-> busy); // R1
  AST_LOW_BOUND: assert property (@(posedge clk) disable iff (rst) line_oe |-> (low_run < low_cap)); // R2
  AST_WAIT_RELEASED: assert property (@(posedge clk) disable iff (rst) dly_run |-> !line_oe); // R6
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst) done |-> !busy); // R10
  AST_DONE_ONE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R10
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst) !busy |=> $stable(rdata)); // R10
endmodule

bind dbgwire_seq dbgwire_seq_chk #(
  .DIV_W(DIV_W), .ZERO_TC(ZERO_TC), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .line_oe(line_oe),
  .dly_run(dly_run), .tgt_div(tgt_div), .rdata(rdata)
);

// File: tb/dbgwire_seq_tb.sv
`timescale 1ns/1ps
module dbgwire_seq_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_div = 8'd2;
  logic [7:0]  tgt_div = 8'd3;
  logic        req = 1'b0;
  logic [7:0]  cmd_op = '0;
  logic [2:0]  cmd_cls = '0;
  logic [15:0] cmd_addr = '0;
  logic [15:0] cmd_wdata = '0;
  logic        busy, done, line_oe, line_in;
  logic [15:0] rdata;
  int          tgt_cnt = 0;
  int          n_chk = 0;
  int          n_fail = 0;

  assign line_in = ~(line_oe | (tgt_cnt != 0));

  always #2.5 clk = ~clk;

  dbgwire_seq u_dut (
    .clk(clk), .rst(rst), .bus_div(bus_div), .tgt_div(tgt_div), .req(req),
    .cmd_op(cmd_op), .cmd_cls(cmd_cls), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .busy(busy), .done(done), .rdata(rdata), .line_oe(line_oe), .line_in(line_in)
  );

  task automatic check(input bit ok, input string r, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  function automatic string wait_tag(input logic [2:0] c);
    if (c == 3'd1 || c == 3'd2) return "R6";
    if (c == 3'd3 || c == 3'd4) return "R7";
    if (c == 3'd5) return "R8";
    return "R4";
  endfunction

  // Issue one command and judge the whole frame at the line.
  task automatic run_frame(input logic [2:0] cls, input logic [7:0] op, input logic [15:0] addr,
                           input logic [15:0] wd, input logic [15:0] resp, input bit poke);
    bit   kind_rx[64];
    bit   ebit[64];
    int   gap[64];
    int   st[64];
    int   lw[64];
    int   n = 0, post = 0, ncell = 0, t = 0, rxi = 0, busy_gap = 0, ndone = 0, tdone = 0;
    int   td = (tgt_div == 0) ? 1 : int'(tgt_div);
    int   bd = (bus_div == 0) ? 1 : int'(bus_div);
    bit   prev = 0;
    logic [15:0] rd_before = rdata;
    for (int i = 0; i < 64; i++) begin gap[i] = 0; st[i] = 0; lw[i] = 0; end
    for (int i = 7; i >= 0; i--) begin kind_rx[n] = 0; ebit[n] = op[i]; n++; end
    if (cls == 3'd1 || cls == 3'd2)
      for (int i = 15; i >= 0; i--) begin kind_rx[n] = 0; ebit[n] = addr[i]; n++; end
    if (cls == 3'd2 || cls == 3'd4)
      for (int i = 15; i >= 0; i--) begin kind_rx[n] = 0; ebit[n] = wd[i]; n++; end
    if (cls == 3'd1 || cls == 3'd3) begin
      gap[n] = (cls == 3'd1) ? 150 : 48;
      for (int i = 15; i >= 0; i--) begin kind_rx[n] = 1; ebit[n] = resp[i]; n++; end
    end
    if (cls == 3'd2) post = 150;
    if (cls == 3'd4) post = 36;
    if (cls == 3'd5) post = 76;

    cmd_cls = cls; cmd_op = op; cmd_addr = addr; cmd_wdata = wd; req = 1'b1;
    while (t < 30000) begin
      @(negedge clk);
      t++;
      if (!poke && t == 1) req = 1'b0;
      if (poke && t == 30) begin
        cmd_cls = 3'd0; cmd_op = ~op; cmd_wdata = ~wd; cmd_addr = ~addr;
      end
      if (poke && t >= 2 && t < 30) req = 1'b0;
      if (poke && t >= 30) req = 1'b1;
      if (tgt_cnt > 0) tgt_cnt--;
      if (line_oe && !prev && ncell < 64) begin
        st[ncell] = t;
        if (ncell < n && kind_rx[ncell] && !ebit[ncell]) tgt_cnt = 13 * td;
        if (ncell < n && kind_rx[ncell]) rxi++;
        ncell++;
      end
      if (!line_oe && prev && ncell > 0) lw[ncell-1] = t - st[ncell-1];
      prev = line_oe;
      if (t > 3 && !busy && !done && ndone == 0) busy_gap++;
      if (done) begin
        ndone++; tdone = t; req = 1'b0;
        @(negedge clk);
        if (done) ndone++;
        break;
      end
    end
    req = 1'b0;
    check(ndone == 1, "R10 done single pulse", ndone, 1);
    check(busy_gap == 0, "R10 busy held to done", busy_gap, 0);
    check(ncell == n, "R4 cell count", ncell, n);
    for (int c = 0; c < n && c < ncell; c++) begin
      int el = (kind_rx[c] || ebit[c]) ? 4 * td : 13 * td;
      check(lw[c] == el, kind_rx[c] ? "R5 read cell low width" : "R2 R3 cell low width", lw[c], el);
      if (c > 0) begin
        int d = st[c] - st[c-1] - 16 * td;
        int g = gap[c] * bd;
        check(d >= g && d <= g + 4, (g == 0) ? "R2 cell spacing" : wait_tag(cls), d, g);
      end
    end
    if (ncell == n && n > 0) begin
      int d = tdone - (st[n-1] + 16 * td);
      check(d >= post * bd && d <= post * bd + 4, (post == 0) ? "R4 finish" : wait_tag(cls), d, post * bd);
    end
    if (cls == 3'd1 || cls == 3'd3) check(rdata == resp, "R5 read data", rdata, resp);
    else check(rdata == rd_before, "R10 rdata kept", rdata, rd_before);
  endtask

  task automatic quiet_window(input string r, input int cycles);
    int seen = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (line_oe || busy || done) seen++;
    end
    check(seen == 0, r, seen, 0);
  endtask

  task automatic t_reset_state;
    @(negedge clk);
    check(!busy && !done && !line_oe, "R1 idle outputs after reset", {busy, done, line_oe}, 0);
    check(rdata == 16'h0, "R1 rdata after reset", rdata, 0);
  endtask

  task automatic t_hold_off;
    run_frame(3'd2, 8'hC3, 16'h8001, 16'h5AC3, 16'h0, 1'b1);
    quiet_window("R9 no frame from request during busy", 60);
  endtask

  task automatic t_reset_mid;
    cmd_cls = 3'd1; cmd_op = 8'h71; cmd_addr = 16'h00FF; req = 1'b1;
    @(negedge clk); req = 1'b0;
    repeat (120) @(negedge clk);
    rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check(!busy && !line_oe, "R11 line released after reset", {busy, line_oe}, 0);
    quiet_window("R11 idle after mid-frame reset", 40);
    run_frame(3'd3, 8'h3C, 16'h0, 16'h0, 16'h6C19, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired R1 actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset_state();                                          // R1
    run_frame(3'd0, 8'hA5, 16'h0, 16'h0, 16'h0, 1'b0);        // R2 R3
    run_frame(3'd1, 8'hE4, 16'h1234, 16'h0, 16'hBEEF, 1'b0);  // R5 R6
    t_hold_off();                                             // R9 R6
    run_frame(3'd3, 8'h0D, 16'h0, 16'h0, 16'h0F0F, 1'b0);     // R7
    run_frame(3'd4, 8'h52, 16'h0, 16'hFFFF, 16'h0, 1'b0);     // R7
    run_frame(3'd5, 8'h08, 16'h0, 16'h0, 16'h0, 1'b0);        // R8
    run_frame(3'd7, 8'h81, 16'h0, 16'h0, 16'h0, 1'b0);        // R4
    tgt_div = 8'd1; bus_div = 8'd4;
    run_frame(3'd1, 8'h96, 16'hF00F, 16'h0, 16'h8001, 1'b0);  // R2 R6
    run_frame(3'd2, 8'h11, 16'h4321, 16'h0000, 16'h0, 1'b0);  // R6
    t_reset_mid();                                            // R11
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule